// File: doc/BRIEF.md
# Data-Processing ALU with Condition-Flag Logic

This block performs one of sixteen data-processing operations on a first operand and an already-shifted second operand. Alongside the result it computes the next negative, zero, carry and overflow flags. Each operation is entered with a valid strobe, and its outputs appear one clock later from registers. The outputs are the result, a result write enable, the new flags with a flag write enable, and a status-restore request.

The operations fall into two groups. The adder group covers add and subtract, each with a reversed form and a carry-chained form, plus the compare forms. Subtraction is formed as first + ~second + carry-in, and in this group the carry flag comes from the adder carry-out. The logical group covers AND, XOR, OR, pass, AND-NOT and NOT, along with the test forms. In this group the carry flag is taken from the shifter carry input and overflow keeps its old value. The four compare/test opcodes only set flags and never write a result.

When flag setting is requested, the destination index is the highest register and the opcode is not a compare, the block raises a status-restore request and does not update the flags. The shifter, the register file and the restore itself are handled outside this block.

Top module: `dp_alu_core`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, result_we, flags_we and status_restore are 0 after that edge.
- R2: out_valid equals the in_valid sampled at the previous clock edge, so every accepted operation has exactly one cycle of latency.
- R3: Logical opcodes produce: 0 and 8 a&b, 1 and 9 a^b, 12 a|b, 13 b, 14 a&~b, 15 ~b.
- R4: Adder opcodes produce: 4 and 11 a+b; 5 a+b+C; 2 and 10 a-b; 3 b-a; 6 a-b-(1-C); 7 b-a-(1-C). C is flag_c_in and the sum wraps modulo 2^DATA_W.
- R5: For adder opcodes (2 to 7, 10, 11), flags_out is {N,Z,C,V} from bit 3 down to bit 0. N is the result MSB and Z is set when the result is zero. C is the carry out of the full-width sum, which for subtraction means "no borrow". V is set on signed overflow.
- R6: For logical opcodes, N and Z come from the result, C equals shift_carry and V equals flag_v_in. The bit positions are the same as in R5.
- R7: result_we is 1 for every valid operation except opcodes 8 to 11 (opcode[3:2] = 2'b10), for which it is 0.
- R8: flags_we is 1 only for a valid operation with set_flags = 1 that does not raise a status restore. With set_flags = 0, both flags_we and status_restore are 0.
- R9: status_restore is 1 for a valid operation with set_flags = 1, dest_idx all ones and an opcode outside 8 to 11; flags_we is then 0. A compare opcode with dest_idx all ones updates the flags instead.
- R10: In a cycle with out_valid = 0, result_we, flags_we and status_restore are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| opcode | input | 4 | Operation select, 0 to 15 |
| set_flags | input | 1 | Request a flag update |
| dest_idx | input | REG_IDX_W | Destination register index |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Shifted second operand |
| flag_c_in | input | 1 | Current carry flag |
| flag_v_in | input | 1 | Current overflow flag |
| shift_carry | input | 1 | Carry out of the shifter |
| out_valid | output | 1 | Registered results are valid |
| result | output | DATA_W | Operation result |
| result_we | output | 1 | Write result to the destination |
| flags_out | output | 4 | New flags {N,Z,C,V} |
| flags_we | output | 1 | Write flags_out to the flag register |
| status_restore | output | 1 | Request a restore of the saved status |

## Verification
The bench uses the default parameters: DATA_W = 32 and REG_IDX_W = 4. With these values the carry out of bit 31 and signed overflow at the 32-bit boundary can be reached, and a destination index of 15 triggers the restore path. Expected values come from a model that works on 64-bit integers and uses true subtraction with a borrow, not the hardware's inverted-operand form. The stimulus covers the wrap-around corners of every adder opcode under both carry-flag values, and every logical opcode with both values of the shifter carry. It also covers back-to-back issue with idle gaps and randomized operation streams.

// File: rtl/dp_alu_pkg.sv
// Shared types for the data-processing ALU.
// Assumes opcode numbering 0..15 as listed in the brief.
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND    = 4'd0,
        OP_XOR    = 4'd1,
        OP_SUB    = 4'd2,
        OP_RSUB   = 4'd3,
        OP_ADD    = 4'd4,
        OP_ADDC   = 4'd5,
        OP_SUBC   = 4'd6,
        OP_RSUBC  = 4'd7,
        OP_TSTAND = 4'd8,
        OP_TSTXOR = 4'd9,
        OP_CMPSUB = 4'd10,
        OP_CMPADD = 4'd11,
        OP_OR     = 4'd12,
        OP_PASS   = 4'd13,
        OP_ANDN   = 4'd14,
        OP_NOT    = 4'd15
    } dp_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    typedef struct packed {
        logic     is_arith;
        logic     is_compare;
        logic     swap;
        logic     inv_second;
        cin_sel_e cin;
    } op_class_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/dp_opdecode.sv
// Opcode classifier: adder vs logical group, compare-only group,
// and the adder controls (operand swap, inversion, carry-in source).
// Assumes a 4-bit opcode; purely combinational.
module dp_opdecode
    import dp_alu_pkg::*;
(
    input  logic [3:0] opcode,
    output op_class_t  cls
);

    // Derive group membership and adder steering from the opcode bits.
    always_comb begin
        cls            = '0;
        cls.is_arith   = (opcode[2] | opcode[1]) & (~opcode[3] | ~opcode[2]);
        cls.is_compare = (opcode[3:2] == 2'b10);
        cls.cin        = CIN_ZERO;
        unique case (dp_op_e'(opcode))
            OP_SUB, OP_CMPSUB: begin cls.inv_second = 1'b1; cls.cin = CIN_ONE;  end
            OP_RSUB:           begin cls.inv_second = 1'b1; cls.swap = 1'b1; cls.cin = CIN_ONE; end
            OP_ADDC:           begin cls.cin = CIN_FLAG; end
            OP_SUBC:           begin cls.inv_second = 1'b1; cls.cin = CIN_FLAG; end
            OP_RSUBC:          begin cls.inv_second = 1'b1; cls.swap = 1'b1; cls.cin = CIN_FLAG; end
            default:           begin cls.cin = CIN_ZERO; end
        endcase
    end

endmodule

// File: rtl/dp_adder.sv
// Adder path: x + y + cin, where x/y are the operands optionally swapped
// and the second one optionally inverted. Gives sum, carry-out, overflow.
// Assumes DATA_W >= 2; purely combinational.
module dp_adder
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              swap,
    input  logic              inv_second,
    input  cin_sel_e          cin_sel,
    input  logic              c_flag,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] x, y_raw, y;
    logic              cin;

    // Select and condition the adder inputs.
    always_comb begin
        x     = swap ? op_b : op_a;
        y_raw = swap ? op_a : op_b;
        y     = inv_second ? ~y_raw : y_raw;
        unique case (cin_sel)
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = c_flag;
            default:  cin = 1'b0;
        endcase
    end

    // Full-width sum with carry and signed-overflow detection.
    always_comb begin
        {cout, sum} = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
        ovf         = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end

endmodule

// File: rtl/dp_logic.sv
// Bitwise unit for the logical opcodes; outputs zero for adder opcodes.
// Assumes op_b is already shifted; purely combinational.
module dp_logic
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] res
);

    // Bitwise function selected by opcode.
    always_comb begin
        unique case (dp_op_e'(opcode))
            OP_AND, OP_TSTAND: res = op_a & op_b;
            OP_XOR, OP_TSTXOR: res = op_a ^ op_b;
            OP_OR:             res = op_a | op_b;
            OP_PASS:           res = op_b;
            OP_ANDN:           res = op_a & ~op_b;
            OP_NOT:            res = ~op_b;
            default:           res = '0;
        endcase
    end

endmodule

// File: rtl/dp_flag_sel.sv
// Flag former: N and Z from the result; C and V from the adder for the
// adder group, from shifter carry and the old V for the logical group.
// Purely combinational.
module dp_flag_sel
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res,
    input  logic              is_arith,
    input  logic              add_cout,
    input  logic              add_ovf,
    input  logic              shift_carry,
    input  logic              old_v,
    output nzcv_t             flags
);

    // Pick flag sources by operation group.
    always_comb begin
        flags.n = res[DATA_W-1];
        flags.z = (res == '0);
        flags.c = is_arith ? add_cout : shift_carry;
        flags.v = is_arith ? add_ovf  : old_v;
    end

endmodule

// File: rtl/dp_alu_core.sv
// Data-processing ALU top: decodes the opcode, runs the adder and logic
// units, forms flags and write enables, and registers all outputs with
// one cycle of latency. Synchronous active-low reset.
// Assumes the restore destination is the all-ones register index.
module dp_alu_core
    import dp_alu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [3:0]           opcode,
    input  logic                 set_flags,
    input  logic [REG_IDX_W-1:0] dest_idx,
    input  logic [DATA_W-1:0]    op_a,
    input  logic [DATA_W-1:0]    op_b,
    input  logic                 flag_c_in,
    input  logic                 flag_v_in,
    input  logic                 shift_carry,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    result,
    output logic                 result_we,
    output logic [3:0]           flags_out,
    output logic                 flags_we,
    output logic                 status_restore
);
    localparam logic [REG_IDX_W-1:0] RESTORE_IDX = {REG_IDX_W{1'b1}};

    op_class_t         cls;
    logic [DATA_W-1:0] add_sum, logic_res, res_next;
    logic              add_cout, add_ovf;
    nzcv_t             flags_next;
    logic              restore_next, flag_upd_next, wr_next;

    dp_opdecode u_dec (
        .opcode (opcode),
        .cls    (cls)
    );

    dp_adder #(.DATA_W(DATA_W)) u_add (
        .op_a       (op_a),
        .op_b       (op_b),
        .swap       (cls.swap),
        .inv_second (cls.inv_second),
        .cin_sel    (cls.cin),
        .c_flag     (flag_c_in),
        .sum        (add_sum),
        .cout       (add_cout),
        .ovf        (add_ovf)
    );

    dp_logic #(.DATA_W(DATA_W)) u_log (
        .opcode (opcode),
        .op_a   (op_a),
        .op_b   (op_b),
        .res    (logic_res)
    );

    // Choose the result from the active unit.
    always_comb res_next = cls.is_arith ? add_sum : logic_res;

    dp_flag_sel #(.DATA_W(DATA_W)) u_flg (
        .res         (res_next),
        .is_arith    (cls.is_arith),
        .add_cout    (add_cout),
        .add_ovf     (add_ovf),
        .shift_carry (shift_carry),
        .old_v       (flag_v_in),
        .flags       (flags_next)
    );

    // Form the write-enable and restore decisions for this operation.
    always_comb begin
        restore_next  = in_valid & set_flags & (dest_idx == RESTORE_IDX) & ~cls.is_compare;
        flag_upd_next = in_valid & set_flags & ~restore_next;
        wr_next       = in_valid & ~cls.is_compare;
    end

    // Output register stage; data holds when no operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            result_we      <= 1'b0;
            flags_we       <= 1'b0;
            status_restore <= 1'b0;
            result         <= '0;
            flags_out      <= '0;
        end else begin
            out_valid      <= in_valid;
            result_we      <= wr_next;
            flags_we       <= flag_upd_next;
            status_restore <= restore_next;
            if (in_valid) begin
                result    <= res_next;
                flags_out <= flags_next;
            end
        end
    end

endmodule

// File: rtl/dp_alu_chk.sv
// Property checker for dp_alu_core, bound to every instance.
module dp_alu_chk #(
    parameter int DATA_W    = 32,
    parameter int REG_IDX_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [3:0]           opcode,
    input logic                 set_flags,
    input logic [REG_IDX_W-1:0] dest_idx,
    input logic                 shift_carry,
    input logic                 flag_v_in,
    input logic                 out_valid,
    input logic [DATA_W-1:0]    result,
    input logic                 result_we,
    input logic [3:0]           flags_out,
    input logic                 flags_we,
    input logic                 status_restore
);
    logic logic_op;
    always_comb logic_op = !((opcode[2] | opcode[1]) & (~opcode[3] | ~opcode[2]));

    p_reset_r1: assert property (@(posedge clk) !rst_n |=> !out_valid && !status_restore);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_nolatency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_we) |-> (flags_out[2] == (result == '0)));

    p_logic_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && logic_op) |=> (flags_out[1] == $past(shift_carry)));

    p_logic_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && logic_op) |=> (flags_out[0] == $past(flag_v_in)));

    p_cmp_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[3:2] == 2'b10) |=> !result_we);

    p_noflags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !set_flags) |=> (!flags_we && !status_restore));

    p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags && dest_idx == {REG_IDX_W{1'b1}} && opcode[3:2] != 2'b10)
        |=> (status_restore && !flags_we));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!result_we && !flags_we && !status_restore));

endmodule

bind dp_alu_core dp_alu_chk #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) u_chk (.*);

// File: tb/sim_dp_alu_core.sv
// Scoreboard bench for dp_alu_core.
module sim_dp_alu_core;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int IW = 4;

    typedef struct {
        logic [DW-1:0] res;
        logic [3:0]    flg;
        bit            rwe, fwe, rst, arith;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    opcode = '0;
    logic          set_flags = 1'b0;
    logic [IW-1:0] dest_idx = '0;
    logic [DW-1:0] op_a = '0, op_b = '0;
    logic          flag_c_in = 1'b0, flag_v_in = 1'b0, shift_carry = 1'b0;
    logic          out_valid, result_we, flags_we, status_restore;
    logic [DW-1:0] result;
    logic [3:0]    flags_out;

    int   total = 0;
    int   bad = 0;
    bit   mon_on = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_alu_core #(.DATA_W(DW), .REG_IDX_W(IW)) u0 (.*);

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", req, got, exp);
        end
    endtask

    // Reference model using 64-bit integer arithmetic.
    function automatic exp_t model(logic [3:0] op, logic s, logic [IW-1:0] d,
                                   logic [DW-1:0] a, logic [DW-1:0] b,
                                   logic c, logic v, logic sc);
        exp_t   e;
        longint ux, uy, sx, sy, ur, sr, k;
        bit     is_sub, cy, ov;
        logic [DW-1:0] x, y;
        e.arith = (op inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11});
        if (e.arith) begin
            x = (op == 4'd3 || op == 4'd7) ? b : a;
            y = (op == 4'd3 || op == 4'd7) ? a : b;
            is_sub = !(op inside {4'd4, 4'd5, 4'd11});
            ux = longint'({32'b0, x}); uy = longint'({32'b0, y});
            sx = longint'($signed(x)); sy = longint'($signed(y));
            if (is_sub) begin
                k  = (op inside {4'd6, 4'd7}) ? longint'(!c) : 0;
                ur = ux - uy - k; sr = sx - sy - k;
                cy = (ux >= uy + k);
            end else begin
                k  = (op == 4'd5) ? longint'(c) : 0;
                ur = ux + uy + k; sr = sx + sy + k;
                cy = (ur > 64'sd4294967295);
            end
            ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            e.res = ur[DW-1:0];
            e.flg = {e.res[DW-1], e.res == 0, cy, ov};
        end else begin
            case (op)
                4'd0, 4'd8: e.res = a & b;
                4'd1, 4'd9: e.res = a ^ b;
                4'd12:      e.res = a | b;
                4'd13:      e.res = b;
                4'd14:      e.res = a & ~b;
                default:    e.res = ~b;
            endcase
            e.flg = {e.res[DW-1], e.res == 0, sc, v};
        end
        e.rwe = !(op >= 4'd8 && op <= 4'd11);
        e.rst = s && (d == 4'hF) && e.rwe;
        e.fwe = s && !e.rst;
        return e;
    endfunction

    // Driver: apply one operation at a falling edge and push its expectation.
    task automatic drive(logic [3:0] op, logic s, logic [IW-1:0] d,
                         logic [DW-1:0] a, logic [DW-1:0] b,
                         logic c, logic v, logic sc);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; set_flags = s; dest_idx = d;
        op_a = a; op_b = b; flag_c_in = c; flag_v_in = v; shift_carry = sc;
        sb.push_back(model(op, s, d, a, b, c, v, sc));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opcode = $urandom(); set_flags = 1'b1; dest_idx = 4'hF;
        end
    endtask

    // Monitor: compare each valid output with the oldest expectation.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                exp_t e;
                if (sb.size() == 0) begin
                    chk("R2 unexpected out_valid", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk(e.arith ? "R4 result" : "R3 result", result, e.res);
                    chk(e.arith ? "R5 flags" : "R6 flags", flags_out, e.flg);
                    chk("R7 result_we", result_we, e.rwe);
                    chk("R8 flags_we", flags_we, e.fwe);
                    chk("R9 status_restore", status_restore, e.rst);
                end
            end else begin
                chk("R10 idle enables", {result_we, flags_we, status_restore}, 3'b000);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {out_valid, result_we, flags_we, status_restore}, 4'b0000);
        rst_n = 1'b1;
        mon_on = 1;
        // R4/R5: adder corners
        drive(4'd4, 1, 4'd1, 32'h7FFF_FFFF, 32'h1, 0, 0, 0);
        drive(4'd4, 1, 4'd1, 32'hFFFF_FFFF, 32'h1, 0, 0, 0);
        drive(4'd5, 1, 4'd2, 32'hFFFF_FFFE, 32'h1, 1, 0, 0);
        drive(4'd5, 1, 4'd2, 32'hFFFF_FFFE, 32'h1, 0, 0, 0);
        drive(4'd2, 1, 4'd3, 32'h5, 32'h5, 0, 0, 0);
        drive(4'd2, 1, 4'd3, 32'h0, 32'h1, 1, 0, 0);
        drive(4'd2, 1, 4'd3, 32'h8000_0000, 32'h1, 0, 0, 0);
        drive(4'd3, 1, 4'd4, 32'h3, 32'h10, 0, 0, 0);
        drive(4'd6, 1, 4'd5, 32'h10, 32'h3, 0, 0, 0);
        drive(4'd6, 1, 4'd5, 32'h0, 32'h0, 0, 1, 0);
        drive(4'd7, 1, 4'd6, 32'h10, 32'h3, 1, 0, 0);
        drive(4'd7, 1, 4'd6, 32'h3, 32'h3, 0, 0, 0);
        idle(2);
        // R7: compare forms, including destination 15 (R9: flags, not restore)
        drive(4'd10, 1, 4'hF, 32'h8, 32'h9, 1, 1, 1);
        drive(4'd11, 1, 4'hF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0);
        drive(4'd8, 1, 4'd0, 32'hF0F0_0000, 32'h0F0F_0000, 0, 1, 1);
        drive(4'd9, 1, 4'd0, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1, 0, 0);
        // R3/R6: logical ops with both shifter carry values and V held
        drive(4'd0, 1, 4'd1, 32'hFF00_FF00, 32'hF0F0_F0F0, 1, 1, 0);
        drive(4'd1, 1, 4'd1, 32'hFF00_FF00, 32'hF0F0_F0F0, 0, 0, 1);
        drive(4'd12, 1, 4'd1, 32'h0000_0001, 32'h8000_0000, 0, 1, 1);
        drive(4'd13, 1, 4'd1, 32'h1234_5678, 32'h0, 1, 0, 1);
        drive(4'd14, 1, 4'd1, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 1, 0);
        drive(4'd15, 1, 4'd1, 32'h0, 32'hFFFF_FFFF, 1, 0, 1);
        // R8: no flag update without set_flags
        drive(4'd4, 0, 4'hF, 32'h1, 32'h2, 0, 0, 0);
        drive(4'd0, 0, 4'd2, 32'h1, 32'h3, 0, 0, 1);
        // R9: restore on destination 15
        drive(4'd13, 1, 4'hF, 32'h0, 32'h4, 0, 0, 0);
        drive(4'd2, 1, 4'hF, 32'h9, 32'h4, 1, 0, 0);
        idle(3);
        // Random streams with gaps
        for (int i = 0; i < 400; i++) begin
            drive($urandom(), $urandom(), $urandom(),
                  ($urandom_range(0, 3) == 0) ? 32'h7FFF_FFFF : $urandom(),
                  ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom(),
                  $urandom(), $urandom(), $urandom());
            if ($urandom_range(0, 5) == 0) idle(1);
        end
        idle(3);
        chk("R2 all results returned", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule